// File: doc/BRIEF.md
# Windowed Watchdog with Key Sequence

This block is a watchdog timer for a system controller. A free-running counter climbs toward a terminal count picked by a small period-select input. Each choice is a power of two. Software keeps the system alive by writing two key values to the arm register in order: 0x0055 first, then 0x00AA. The second key reloads the counter. If no service arrives before the terminal count, the block raises a reset request.

A window-enable input turns on a stricter mode. In this mode a key write is accepted only in the last quarter of the selected period. A key write that comes too early raises the reset request at once. So does a write whose value is not the expected next key.

Every reset request also sets a sticky cause flag. Downstream reset-vector logic reads this flag to choose the watchdog entry point. The flag is cleared only by power-on reset, so it survives the system reset that the watchdog itself triggers.

Top module: `wdg_window`

## Requirements
- R1: While `rst_n` is low, `rst_req` is 0 and the counter is held at zero. While `por_n` is low, `cause` is 0.
- R2: With no service, `rst_req` is high for exactly one cycle. It rises 2^(4+`per_sel`) clock edges after the counter last restarted at zero, so the period is 16, 32, 64 or 128 cycles.
- R3: A write of 0x0055 followed by a write of 0x00AA is a valid service. It restarts the counter at zero and raises no reset request.
- R4: When the 16-bit write value is not the expected next key, `rst_req` is high in the cycle after the write. The expected next key is 0x0055 when idle and 0x00AA after an accepted 0x0055. Values such as 0x1234, 0x0155, or a second 0x0055 are wrong keys.
- R5: A write of 0x00AA that does not follow an accepted 0x0055 is treated as a wrong key.
- R6: When `win_en` is 1, any key write made while the count is below three quarters of the period raises `rst_req` in the next cycle.
- R7: When `win_en` is 1, key writes made at a count of three quarters of the period or later are accepted.
- R8: When `win_en` is 0, key writes are accepted at any count.
- R9: Any reset request sets `cause`. `cause` stays set through `rst_n` and clears only when `por_n` is low.
- R10: After any reset request, the counter restarts at zero and the key sequence again expects 0x0055.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (async assert) |
| por_n | input | 1 | Active-low power-on reset, clears the cause flag |
| per_sel | input | 2 | Period select, period = 2^(4+per_sel) cycles |
| win_en | input | 1 | Window mode enable |
| wr_en | input | 1 | Arm-register write strobe |
| wr_data | input | 16 | Arm-register write value |
| rst_req | output | 1 | One-cycle reset request |
| cause | output | 1 | Sticky flag: the watchdog requested a reset |

## Verification
A counter that drifts by even one count moves the timeout pulse by one cycle. It also moves the boundary at which a window-mode write is rejected. The bench runs a reference model in step with the design and compares both outputs on every clock, so such a drift shows up in the cycle it happens. A key-state error shows up in the cycle after the next write, either as a missing reset request or as a spurious one. A cause flag that is cleared by the wrong reset shows up right after a system-only reset pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_ARM  = 16'h0055;
    localparam logic [KEY_W-1:0] KEY_FIRE = 16'h00AA;

    typedef enum logic {
        EXPECT_ARM  = 1'b0,
        EXPECT_FIRE = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int BASE_LOG2 = 4,
    parameter int STEP_LOG2 = 1,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] per_sel,
    input  logic             clear,
    output logic             in_window,
    output logic             expired
);
    localparam int NSEL     = 1 << SEL_W;
    localparam int MAX_LOG2 = BASE_LOG2 + (NSEL - 1) * STEP_LOG2;
    localparam int CNT_W    = MAX_LOG2;
    localparam int LIM_W    = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    int               exp_l;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] last;
    logic [LIM_W-1:0] win_start;
    logic [LIM_W-1:0] cnt_ext;

    always_comb begin
        exp_l     = BASE_LOG2 + int'(per_sel) * STEP_LOG2;
        limit     = LIM_W'(1) << exp_l;
        last      = limit - LIM_W'(1);
        win_start = limit - (limit >> 2);
        cnt_ext   = {1'b0, s_q.count};
        in_window = (cnt_ext >= win_start);
        expired   = (cnt_ext >= last);
        s_d = s_q;
        if (clear) s_d.count = '0;
        else       s_d.count = s_q.count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> s_q.count == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> s_q.count == $past(s_q.count) + 1'b1);
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             win_ok,
    input  logic             abort,
    output logic             bad,
    output logic             done
);
    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t        s_d, s_q;
    logic [KEY_W-1:0] want;

    always_comb begin
        want = (s_q.st == EXPECT_FIRE) ? KEY_FIRE : KEY_ARM;
        bad  = wr_en && (!win_ok || wr_data != want);
        done = wr_en && win_ok && s_q.st == EXPECT_FIRE && wr_data == KEY_FIRE;
        s_d  = s_q;
        if (abort || bad)
            s_d.st = EXPECT_ARM;
        else if (wr_en)
            s_d.st = (s_q.st == EXPECT_ARM) ? EXPECT_FIRE : EXPECT_ARM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: EXPECT_ARM};
        else        s_q <= s_d;
    end

    // R5
    fire_without_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.st == EXPECT_ARM && wr_data == KEY_FIRE) |-> bad);

    // R6
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_ok) |-> bad);

    // R3
    done_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> s_q.st == EXPECT_ARM);
endmodule

// File: rtl/wdg_window.sv
module wdg_window
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 4,
    parameter int STEP_LOG2 = 1,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [SEL_W-1:0] per_sel,
    input  logic             win_en,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    output logic             rst_req,
    output logic             cause
);
    typedef struct packed {
        logic req;
    } top_regs_t;

    top_regs_t s_d, s_q;
    logic      cause_d, cause_q;
    logic      in_window, cnt_expired;
    logic      win_ok, key_bad, svc_done, tmo, fire, clear;

    wdg_counter #(
        .BASE_LOG2(BASE_LOG2),
        .STEP_LOG2(STEP_LOG2),
        .SEL_W    (SEL_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_sel  (per_sel),
        .clear    (clear),
        .in_window(in_window),
        .expired  (cnt_expired)
    );

    wdg_keyseq u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .win_ok (win_ok),
        .abort  (tmo),
        .bad    (key_bad),
        .done   (svc_done)
    );

    always_comb begin
        win_ok  = !win_en || in_window;
        tmo     = cnt_expired && !svc_done;
        fire    = key_bad || tmo;
        clear   = fire || svc_done;
        s_d     = s_q;
        s_d.req = fire;
        cause_d = cause_q || (fire && rst_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 1'b0;
        else        cause_q <= cause_d;
    end

    assign rst_req = s_q.req;
    assign cause   = cause_q;

    // R2
    timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_expired && !svc_done) |=> rst_req);

    // R9
    cause_follows_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> cause);

    // R9
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);
endmodule

// File: tb/sim_wdg_window.sv
module sim_wdg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [1:0]  per_sel = 2'd0;
    logic        win_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic        rst_req, cause;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    string tag = "R1";

    int m_cnt = 0;
    bit m_armed = 0;
    bit m_req = 0;
    bit m_cause = 0;

    always #10 clk = ~clk;

    wdg_window u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .per_sel(per_sel),
        .win_en(win_en), .wr_en(wr_en), .wr_data(wr_data),
        .rst_req(rst_req), .cause(cause)
    );

    // behavioural reference
    always @(posedge clk) begin
        int  lim;
        bit  ok, bad, done, tmo, ev;
        cycles++;
        if (!por_n) m_cause = 0;
        if (!rst_n) begin
            m_cnt = 0; m_armed = 0; m_req = 0;
        end else begin
            lim  = 1 << (4 + per_sel);
            ok   = !win_en || (m_cnt >= (lim * 3) / 4);
            bad  = wr_en && (!ok || (m_armed ? wr_data != 16'h00AA : wr_data != 16'h0055));
            done = wr_en && ok && m_armed && wr_data == 16'h00AA;
            tmo  = (m_cnt >= lim - 1) && !done;
            ev   = bad || tmo;
            m_req = ev;
            if (ev && por_n) m_cause = 1;
            if (ev) m_armed = 0;
            else if (wr_en) m_armed = !m_armed;
            if (ev || done) m_cnt = 0;
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (rst_req !== m_req) begin
            miscompares++;
            $display("FAIL %s rst_req actual=%0b expected=%0b", tag, rst_req, m_req);
        end
        if (cause !== m_cause) begin
            miscompares++;
            $display("FAIL %s cause actual=%0b expected=%0b", tag, cause, m_cause);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(int n);
        while (m_cnt != n) tick();
    endtask

    task automatic full_reset();
        rst_n = 1'b0; por_n = 1'b0;
        ticks(3);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        tag = "R1";
        ticks(3);
        rst_n = 1'b1; por_n = 1'b1;
        // R2 timeouts for each period select
        tag = "R2";
        for (int s = 0; s < 4; s++) begin
            per_sel = 2'(s);
            wait_cnt(0);
            ticks((1 << (4 + s)) + 3);
        end
        // R9 cause survives system reset, cleared by power-on reset
        tag = "R9";
        rst_n = 1'b0; ticks(3); rst_n = 1'b1; ticks(2);
        por_n = 1'b0; ticks(2); por_n = 1'b1; ticks(2);
        // R8 service anywhere with window off
        tag = "R8";
        full_reset(); per_sel = 2'd0; win_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            wr(16'h0055); wr(16'h00AA); ticks(10);
        end
        // R3 valid sequence then confirm reload timing
        tag = "R3";
        wr(16'h0055); ticks(4); wr(16'h00AA); ticks(20);
        // R4 wrong values
        tag = "R4";
        wr(16'h1234); ticks(2);
        wr(16'h0155); ticks(2);
        wr(16'h0055); wr(16'h0055); ticks(2);
        // R5 fire key without arm
        tag = "R5";
        wait_cnt(3); wr(16'h00AA); ticks(2);
        // R6 early writes in window mode, including one below boundary
        tag = "R6";
        win_en = 1'b1; per_sel = 2'd1;
        wait_cnt(2); wr(16'h0055); ticks(2);
        wait_cnt(23); wr(16'h0055); ticks(2);
        // R7 writes inside the window, including exactly at boundary
        tag = "R7";
        wait_cnt(24); wr(16'h0055); wr(16'h00AA);
        for (int k = 0; k < 3; k++) begin
            wait_cnt(27); wr(16'h0055); wr(16'h00AA);
        end
        ticks(5);
        // R10 after a fault/timeout the sequence restarts at the first key
        tag = "R10";
        win_en = 1'b0; per_sel = 2'd0;
        wait_cnt(1); wr(16'h0055); wr(16'h1111); wr(16'h00AA); ticks(2);
        wait_cnt(2); wr(16'h0055); ticks(20); wr(16'h00AA); ticks(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule